// File: doc/BRIEF.md
# Quadrature Counter Source Selector

This block turns two encoder phase inputs into a count strobe and a direction bit that drive a position counter. A 2-bit source field chooses one of four ways to read the phases. The first is full quadrature decoding, which counts every edge of either phase. The second treats phase A as an external count clock and phase B as the direction level. The last two count fixed up or fixed down on each rising edge of phase A, which suits frequency measurement.

The phase inputs must already be synchronized to the system clock. The block keeps a one-sample history of both phases. On the first clock after reset it only loads that history, so the phase levels present at reset never produce a count. A position counter fed by the strobe and direction outputs is included. It wraps modulo 2^POS_W.

Top module: `qsel_count_source`

## Requirements
- R1: After reset `position` is 0, `cnt_stb` and `phase_err` are 0, and `cnt_dir` is 1.
- R2: With `src_mode` = 2'b00 (quadrature), a change of exactly one phase between two consecutive samples raises `cnt_stb` for one cycle. A full phase cycle therefore gives four strobes. The strobe appears one clock after the sample that shows the change.
- R3: In quadrature mode, a transition in the sequence {A,B} = 00→10→11→01→00 (A leads B) sets `cnt_dir` to 1, and `position` increments on the cycle after the strobe. The reverse sequence sets `cnt_dir` to 0 and `position` decrements. When there is no strobe, `cnt_dir` holds its last value.
- R4: In quadrature mode, a change of both phases in one sample step gives no strobe, leaves `position` unchanged and raises `phase_err` for exactly one cycle.
- R5: With `src_mode` = 2'b01 (direction-count), only a rising edge of A produces a strobe, and `cnt_dir` follows the level of B. A falling A edge or a change on B alone produces no count.
- R6: With `src_mode` = 2'b10 (fixed up), each rising edge of A counts up whatever B does, and `cnt_dir` is 1.
- R7: With `src_mode` = 2'b11 (fixed down), each rising edge of A counts down, and `cnt_dir` is 0.
- R8: `position` wraps modulo 2^POS_W: one count down from 0 gives all ones, and one count up from all ones gives 0.
- R9: The first clock after reset loads the phase history only. It produces no strobe and no phase error, whatever the phase levels are.
- R10: In the three external-clock modes, `phase_err` stays 0, even when A and B change together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, synchronized; external clock in the non-quadrature modes |
| phase_b | input | 1 | Encoder phase B, synchronized; direction level in direction-count mode |
| src_mode | input | 2 | Count source: 00 quadrature, 01 direction-count, 10 fixed up, 11 fixed down |
| cnt_stb | output | 1 | One-cycle count strobe |
| cnt_dir | output | 1 | Count direction, 1 = up |
| phase_err | output | 1 | One-cycle strobe on an illegal quadrature transition |
| position | output | POS_W | Position counter value |

## Verification
The hardest situations to reach are the illegal quadrature step and the wrap of the 32-bit counter. The illegal step needs both phases to flip within one sample. The bench produces it by driving both inputs on the same falling edge, and only after a reverse sequence, so that it can also confirm that the held direction is left alone. Counting to the wrap point is not practical, so the bench resets, selects fixed-down mode and applies one rising edge of A to reach all ones. It then switches to fixed-up mode and applies one more edge to return to zero.

// File: rtl/qsel_pkg.sv
package qsel_pkg;

   typedef enum logic [1:0] {
      SRC_QUAD   = 2'b00,
      SRC_DIRCNT = 2'b01,
      SRC_UP     = 2'b10,
      SRC_DOWN   = 2'b11
   } src_mode_e;

   // request produced by a decoder for one sample step
   typedef struct packed {
      logic stb;        // count this step
      logic dir;        // 1 = up
      logic dir_upd;    // direction value is meaningful this step
      logic err;        // illegal transition seen
   } cnt_req_t;

endpackage

// File: rtl/qsel_phase_hist.sv
module qsel_phase_hist (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       phase_a,
   input  logic       phase_b,
   output logic [1:0] prev_ab,
   output logic       primed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ab <= 2'b00;
         primed  <= 1'b0;
      end else begin
         prev_ab <= {phase_a, phase_b};
         primed  <= 1'b1;
      end
   end

   // R9
   primed_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |=> primed);

endmodule

// File: rtl/qsel_quad_dec.sv
module qsel_quad_dec
   import qsel_pkg::*;
(
   input  logic [1:0] cur_ab,
   input  logic [1:0] prev_ab,
   input  logic       primed,
   output cnt_req_t   req
);

   logic [1:0] delta;

   always_comb begin
      delta       = cur_ab ^ prev_ab;
      req.stb     = primed && (delta[1] ^ delta[0]);
      req.err     = primed && (delta[1] & delta[0]);
      // forward Gray order 00,10,11,01 on {A,B}
      req.dir     = cur_ab[1] ^ prev_ab[0];
      req.dir_upd = req.stb;
   end

endmodule

// File: rtl/qsel_ext_dec.sv
module qsel_ext_dec
   import qsel_pkg::*;
(
   input  logic       cur_a,
   input  logic       cur_b,
   input  logic       prev_a,
   input  logic       primed,
   input  src_mode_e  mode,
   output cnt_req_t   req
);

   always_comb begin
      req.stb     = primed && cur_a && !prev_a;
      req.err     = 1'b0;
      req.dir_upd = 1'b1;
      unique case (mode)
         SRC_UP:   req.dir = 1'b1;
         SRC_DOWN: req.dir = 1'b0;
         default:  req.dir = cur_b;
      endcase
   end

endmodule

// File: rtl/qsel_pos_counter.sv
module qsel_pos_counter #(
   parameter int POS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             dir,
   output logic [POS_W-1:0] position
);

   localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         position <= '0;
      else if (stb)
         position <= dir ? position + ONE : position - ONE;
   end

   // R3
   pos_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && dir) |=> position == $past(position) + ONE);

   // R3
   pos_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !dir) |=> position == $past(position) - ONE);

   // R4
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(position));

endmodule

// File: rtl/qsel_count_source.sv
module qsel_count_source
   import qsel_pkg::*;
#(
   parameter int POS_W   = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase_a,
   input  logic             phase_b,
   input  logic [1:0]       src_mode,
   output logic             cnt_stb,
   output logic             cnt_dir,
   output logic             phase_err,
   output logic [POS_W-1:0] position
);

   localparam int MIN_POS_W = 2;

   if (POS_W < MIN_POS_W) begin : g_bad_width
      $error("qsel_count_source: POS_W must be at least %0d", MIN_POS_W);
   end

   src_mode_e  mode;
   logic [1:0] cur_ab;
   logic [1:0] prev_ab;
   logic       primed;
   cnt_req_t   quad_req;
   cnt_req_t   ext_req;
   cnt_req_t   sel_req;
   logic       dir_hold;

   assign mode   = src_mode_e'(src_mode);
   assign cur_ab = {phase_a, phase_b};

   qsel_phase_hist u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_a (phase_a),
      .phase_b (phase_b),
      .prev_ab (prev_ab),
      .primed  (primed)
   );

   qsel_quad_dec u_quad (
      .cur_ab  (cur_ab),
      .prev_ab (prev_ab),
      .primed  (primed),
      .req     (quad_req)
   );

   qsel_ext_dec u_ext (
      .cur_a   (phase_a),
      .cur_b   (phase_b),
      .prev_a  (prev_ab[1]),
      .primed  (primed),
      .mode    (mode),
      .req     (ext_req)
   );

   assign sel_req = (mode == SRC_QUAD) ? quad_req : ext_req;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_stb   <= 1'b0;
            phase_err <= 1'b0;
            dir_hold  <= 1'b1;
         end else begin
            cnt_stb   <= sel_req.stb;
            phase_err <= sel_req.err;
            if (sel_req.dir_upd)
               dir_hold <= sel_req.dir;
         end
      end
      assign cnt_dir = dir_hold;

      // R9
      first_step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !primed |=> (!cnt_stb && !phase_err));

      // R10
      ext_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode != SRC_QUAD) |=> !phase_err);

      // R5
      dircnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode != SRC_QUAD && !phase_a) |=> !cnt_stb);

      // R6
      up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SRC_UP) |=> cnt_dir);

      // R7
      down_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SRC_DOWN) |=> !cnt_dir);
   end else begin : g_comb_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dir_hold <= 1'b1;
         else if (sel_req.dir_upd)
            dir_hold <= sel_req.dir;
      end
      assign cnt_stb   = sel_req.stb;
      assign phase_err = sel_req.err;
      assign cnt_dir   = sel_req.dir_upd ? sel_req.dir : dir_hold;
   end

   // R4
   err_excl_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phase_err && cnt_stb));

   // R4
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_err |=> !phase_err);

   qsel_pos_counter #(.POS_W(POS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (cnt_stb),
      .dir      (cnt_dir),
      .position (position)
   );

endmodule

// File: tb/qsel_count_source_tb.sv
module qsel_count_source_tb;

   localparam int POS_W = 32;

   logic             clk;
   logic             rst_n;
   logic             phase_a;
   logic             phase_b;
   logic [1:0]       src_mode;
   logic             cnt_stb;
   logic             cnt_dir;
   logic             phase_err;
   logic [POS_W-1:0] position;

   int checks = 0;
   int errors = 0;
   logic [POS_W-1:0] exp_pos;

   qsel_count_source #(.POS_W(POS_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_a   (phase_a),
      .phase_b   (phase_b),
      .src_mode  (src_mode),
      .cnt_stb   (cnt_stb),
      .cnt_dir   (cnt_dir),
      .phase_err (phase_err),
      .position  (position)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check_bit(input string req, input string what,
                            input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic check_pos(input string req, input logic [POS_W-1:0] exp);
      checks++;
      if (position !== exp) begin
         errors++;
         $display("FAIL %s position: actual %h expected %h", req, position, exp);
      end
   endtask

   // drive one sample step, check outputs one cycle later, then the
   // counter and the return of the strobes to zero a cycle after that
   task automatic step(input string req, input logic [1:0] mode,
                       input logic a, input logic b,
                       input logic e_stb, input logic e_dir, input logic e_err,
                       input int delta);
      @(negedge clk);
      src_mode = mode;
      phase_a  = a;
      phase_b  = b;
      @(negedge clk);
      check_bit(req, "cnt_stb", cnt_stb, e_stb);
      check_bit(req, "cnt_dir", cnt_dir, e_dir);
      check_bit(req, "phase_err", phase_err, e_err);
      exp_pos = exp_pos + POS_W'(delta);
      @(negedge clk);
      check_pos(req, exp_pos);
      check_bit(req, "cnt_stb single", cnt_stb, 1'b0);
      check_bit(req, "phase_err single", phase_err, 1'b0);
   endtask

   task automatic do_reset(input logic [1:0] mode, input logic a, input logic b);
      @(negedge clk);
      rst_n    = 1'b0;
      src_mode = mode;
      phase_a  = a;
      phase_b  = b;
      exp_pos  = '0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic test_reset_state();
      do_reset(2'b00, 1'b1, 1'b1);
      check_pos("R1", '0);
      check_bit("R1", "cnt_stb", cnt_stb, 1'b0);
      check_bit("R1", "phase_err", phase_err, 1'b0);
      check_bit("R1", "cnt_dir", cnt_dir, 1'b1);
   endtask

   task automatic test_prime();
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R9", "cnt_stb", cnt_stb, 1'b0);
      check_bit("R9", "phase_err", phase_err, 1'b0);
      @(negedge clk);
      check_bit("R9", "cnt_stb later", cnt_stb, 1'b0);
      check_pos("R9", '0);
   endtask

   task automatic test_quad_forward();
      // 11 -> 01 -> 00 -> 10 -> 11, A leads B
      step("R2", 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1);
      step("R3", 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1);
      step("R3", 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1);
      step("R2", 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1);
      check_pos("R2 four counts", 32'd4);
   endtask

   task automatic test_quad_reverse();
      // 11 -> 10 -> 00 -> 01 -> 11, B leads A
      step("R3", 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
      step("R3", 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1);
      step("R3", 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, -1);
      step("R3", 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, -1);
      check_pos("R3 back to zero", '0);
   endtask

   task automatic test_quad_illegal();
      // 11 -> 00: both phases flip, direction stays down
      step("R4", 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      // 00 -> 11: illegal again
      step("R4", 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0);
   endtask

   task automatic test_dir_count();
      // from 11: A falls, B stays high: no count, dir = B
      step("R5", 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
      // A rises with B high: count up
      step("R5", 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1);
      // B alone goes low: no count, dir follows B
      step("R5", 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      // A falls: no count
      step("R5", 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      // A rises with B low: count down
      step("R5", 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
   endtask

   task automatic test_up();
      step("R6", 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
      // A and B both change: counts, no error
      step("R10", 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1);
      step("R6", 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
      step("R6", 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1);
   endtask

   task automatic test_down();
      step("R7", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      step("R7", 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, -1);
      // both change in fixed-down mode: no error, no rising A
      step("R10", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      step("R7", 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
   endtask

   task automatic test_wrap();
      do_reset(2'b11, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      step("R8", 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
      check_pos("R8 all ones", {POS_W{1'b1}});
      step("R8", 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
      step("R8", 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1);
      check_pos("R8 back to zero", '0);
   endtask

   initial begin
      rst_n    = 1'b0;
      phase_a  = 1'b0;
      phase_b  = 1'b0;
      src_mode = 2'b00;
      exp_pos  = '0;
      test_reset_state();
      test_prime();
      test_quad_forward();
      test_quad_reverse();
      test_quad_illegal();
      test_dir_count();
      test_up();
      test_down();
      test_wrap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule